// File: doc/BRIEF.md
# External Bus Address Decoder

This block is the glue logic between an 8-bit microcontroller and the devices on its external data bus. The bus carries a 16-bit address and two active-low strobes, one for reads and one for writes. The block turns these into enables for two kinds of device. The first kind is a set of memory-mapped peripherals in a 16-byte I/O window at the very top of the address space. The second is a 32Kx8 static RAM.

The window gets one active-low region select. Its lower eight offsets are split further into eight separate read strobes and eight separate write strobes, one pair per byte. The RAM gets an active-low chip select, output enable and write enable. A build-time parameter places the RAM in either the lower or the upper half of the address space. In the upper half, the I/O window is cut out of the RAM select.

The microcontroller raises neither strobe for its internal accesses, so nothing on the external bus reacts to them. The block has no clock and no state: every output follows the current inputs.

Top module: `ext_bus_decoder`

## Requirements
- R1: While both `rd_n_i` and `wr_n_i` are high, every active-low output is high and `bus_err_o` is low.
- R2: `io_sel_n_o` is low exactly when address bits 15..4 are all ones and at least one of `rd_n_i`, `wr_n_i` is low. This holds even when both strobes are low.
- R3: Read strobe `io_rd_n_o[k]` is low exactly when all of the following hold: the I/O window is selected, `rd_n_i` is low, `wr_n_i` is high, address bit 3 is 0 and address bits 2..0 equal k. At most one read strobe is low at any time.
- R4: Write strobe `io_wr_n_o[k]` is low exactly when all of the following hold: the I/O window is selected, `wr_n_i` is low, `rd_n_i` is high, address bit 3 is 0 and address bits 2..0 equal k. At most one write strobe is low at any time.
- R5: Window offsets 8 to 15 (address bit 3 = 1) assert no read strobe and no write strobe.
- R6: With `RAM_HALF` = RAM_LOW (value 0), `ram_cs_n_o` is low exactly when address bit 15 is 0 and exactly one strobe is low.
- R7: With `RAM_HALF` = RAM_HIGH (value 1), `ram_cs_n_o` is low exactly when address bit 15 is 1, the address is outside the top 16 bytes, and exactly one strobe is low.
- R8: `ram_oe_n_o` equals `rd_n_i` and `ram_we_n_o` equals `wr_n_i`, except when both strobes are low.
- R9: When both strobes are low, `bus_err_o` is high, all per-byte strobes are high, and `ram_cs_n_o`, `ram_oe_n_o` and `ram_we_n_o` are high. In every other case `bus_err_o` is low.
- R10: Every output settles within the same time step as an input change, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | External bus address |
| rd_n_i | input | 1 | Active-low read strobe from the microcontroller |
| wr_n_i | input | 1 | Active-low write strobe from the microcontroller |
| io_sel_n_o | output | 1 | Active-low select for the 16-byte I/O window |
| io_rd_n_o | output | 8 | Active-low per-byte read strobes, index = address bits 2..0 |
| io_wr_n_o | output | 8 | Active-low per-byte write strobes, index = address bits 2..0 |
| ram_cs_n_o | output | 1 | Active-low RAM chip select |
| ram_oe_n_o | output | 1 | Active-low RAM output enable |
| ram_we_n_o | output | 1 | Active-low RAM write enable |
| bus_err_o | output | 1 | High when both strobes are low at once |

## Verification
Every result of this decoder is due zero cycles after its stimulus. The select, the per-byte strobes, the RAM enables and the error flag all follow the address and strobe inputs through gates alone. The bench therefore never waits for a clock edge before it compares. It changes the inputs, lets 1 ns of delta settling pass, and samples in the middle of a 2 ns step. The next stimulus is applied only after that step. The clock is used only to pace the reset phase and the watchdog.

// File: rtl/bus_dec_pkg.sv
// Package: bus_dec_pkg
// Shared types and default geometry for the external bus decoder.
// Assumes a byte-wide bus with a single flat address space.
package bus_dec_pkg;

    // Placement of the static RAM within the address space
    typedef enum logic {
        RAM_LOW  = 1'b0,
        RAM_HIGH = 1'b1
    } ram_half_e;

    localparam int unsigned DEF_ADDR_W   = 16; // bus address width
    localparam int unsigned DEF_IO_BITS  = 4;  // log2 of I/O window size
    localparam int unsigned DEF_STB_BITS = 3;  // log2 of strobe count

endpackage

// File: rtl/bus_cycle_qual.sv
// Module: bus_cycle_qual
// Classifies the strobe pair into idle, legal read, legal write or the
// illegal both-low state.
// Assumes the strobes are already synchronous to the bus; there is no filtering.
module bus_cycle_qual (
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic cyc_act_o,  // any external cycle in progress
    output logic cyc_err_o,  // both strobes low
    output logic rd_ok_o,    // legal read cycle
    output logic wr_ok_o     // legal write cycle
);

    // Decode the strobe pair into qualified cycle flags
    always_comb begin
        cyc_act_o = ~(rd_n_i & wr_n_i);
        cyc_err_o = ~rd_n_i & ~wr_n_i;
        rd_ok_o   = ~rd_n_i &  wr_n_i;
        wr_ok_o   =  rd_n_i & ~wr_n_i;
    end

    // Check that legal read, legal write and error never coincide (R9)
    always_comb begin
        if (!$isunknown({rd_n_i, wr_n_i})) begin
            a_r9_exclusive_kinds: assert ($countones({rd_ok_o, wr_ok_o, cyc_err_o}) <= 1)
                else $error("cycle kinds overlap");
        end
    end

endmodule

// File: rtl/io_strobe_dec.sv
// Module: io_strobe_dec
// Splits the lower part of the I/O window into one-hot active-low read
// and write strobes.
// Assumes IO_BITS > STB_BITS. Offsets whose upper offset bits are not zero
// produce no strobe.
module io_strobe_dec #(
    parameter int unsigned IO_BITS  = bus_dec_pkg::DEF_IO_BITS,
    parameter int unsigned STB_BITS = bus_dec_pkg::DEF_STB_BITS,
    localparam int unsigned N_STB   = 1 << STB_BITS
) (
    input  logic               io_hit_i,  // window selected, cycle active
    input  logic               rd_ok_i,   // legal read cycle
    input  logic               wr_ok_i,   // legal write cycle
    input  logic [IO_BITS-1:0] offs_i,    // offset within the window
    output logic [N_STB-1:0]   rd_stb_n_o,
    output logic [N_STB-1:0]   wr_stb_n_o
);

    logic lower_part;  // offset lies in the strobe-decoded part

    // Keep strobes to offsets whose bits above the strobe index are zero
    always_comb lower_part = ~|offs_i[IO_BITS-1:STB_BITS];

    for (genvar k = 0; k < N_STB; k++) begin : g_stb
        logic idx_match;
        // Match this strobe's index against the low offset bits
        always_comb idx_match = io_hit_i & lower_part && (offs_i[STB_BITS-1:0] == STB_BITS'(k));
        // Drive the read and write strobes for byte k
        always_comb begin
            rd_stb_n_o[k] = ~(idx_match & rd_ok_i);
            wr_stb_n_o[k] = ~(idx_match & wr_ok_i);
        end
    end

    // At most one strobe per direction, none in the upper offsets (R3, R4, R5)
    always_comb begin
        if (!$isunknown({io_hit_i, rd_ok_i, wr_ok_i, offs_i})) begin
            a_r3_rd_onehot: assert ($countones(~rd_stb_n_o) <= 1)
                else $error("several read strobes low");
            a_r4_wr_onehot: assert ($countones(~wr_stb_n_o) <= 1)
                else $error("several write strobes low");
            a_r5_upper_quiet: assert (lower_part || (&rd_stb_n_o && &wr_stb_n_o))
                else $error("strobe in upper offsets");
        end
    end

endmodule

// File: rtl/sram_sel.sv
// Module: sram_sel
// Generates the RAM chip select and the output and write enables.
// Assumes a RAM that fills exactly one half of the address space. In the
// upper half, the I/O window is excluded from the select.
module sram_sel #(
    parameter bus_dec_pkg::ram_half_e RAM_HALF = bus_dec_pkg::RAM_LOW
) (
    input  logic a_msb_i,    // top address bit
    input  logic cyc_act_i,  // any external cycle
    input  logic cyc_err_i,  // illegal both-low strobes
    input  logic io_hit_i,   // I/O window selected
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic cs_n_o,
    output logic oe_n_o,
    output logic we_n_o
);

    logic half_hit;  // address lies in the RAM's half

    if (RAM_HALF == bus_dec_pkg::RAM_HIGH) begin : g_high
        // Upper half: top bit set, I/O window cut out
        always_comb half_hit = a_msb_i & ~io_hit_i;
    end else begin : g_low
        // Lower half: top bit clear
        always_comb half_hit = ~a_msb_i;
    end

    // Combine the region hit with the cycle qualifiers
    always_comb begin
        cs_n_o = ~(half_hit & cyc_act_i & ~cyc_err_i);
        oe_n_o = rd_n_i | cyc_err_i;
        we_n_o = wr_n_i | cyc_err_i;
    end

    // Upper RAM never overlaps the window; the error state silences the RAM (R7, R9)
    always_comb begin
        if (!$isunknown({a_msb_i, cyc_act_i, cyc_err_i, io_hit_i, rd_n_i, wr_n_i})) begin
            a_r7_no_window_overlap: assert (RAM_HALF != bus_dec_pkg::RAM_HIGH || !(io_hit_i && !cs_n_o))
                else $error("RAM selected inside I/O window");
            a_r9_ram_quiet: assert (!cyc_err_i || (cs_n_o && oe_n_o && we_n_o))
                else $error("RAM enabled on illegal cycle");
        end
    end

endmodule

// File: rtl/ext_bus_decoder.sv
// Module: ext_bus_decoder
// Address decoder for a byte-wide external bus. It provides an I/O window
// at the top of the map with per-byte strobes, and enables for a static
// RAM in one half of the map.
// Purely combinational; assumes the address is stable while a strobe is low.
module ext_bus_decoder #(
    parameter int unsigned ADDR_W   = bus_dec_pkg::DEF_ADDR_W,
    parameter int unsigned IO_BITS  = bus_dec_pkg::DEF_IO_BITS,
    parameter int unsigned STB_BITS = bus_dec_pkg::DEF_STB_BITS,
    parameter bus_dec_pkg::ram_half_e RAM_HALF = bus_dec_pkg::RAM_LOW,
    localparam int unsigned N_STB   = 1 << STB_BITS
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    output logic              io_sel_n_o,
    output logic [N_STB-1:0]  io_rd_n_o,
    output logic [N_STB-1:0]  io_wr_n_o,
    output logic              ram_cs_n_o,
    output logic              ram_oe_n_o,
    output logic              ram_we_n_o,
    output logic              bus_err_o
);

    logic cyc_act, cyc_err, rd_ok, wr_ok;
    logic io_hit;

    bus_cycle_qual u_qual (
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .cyc_act_o (cyc_act),
        .cyc_err_o (cyc_err),
        .rd_ok_o   (rd_ok),
        .wr_ok_o   (wr_ok)
    );

    // Window hit: all address bits above the window are ones during a cycle
    always_comb io_hit = (&addr_i[ADDR_W-1:IO_BITS]) & cyc_act;

    // Drive the region select and the error flag
    always_comb begin
        io_sel_n_o = ~io_hit;
        bus_err_o  = cyc_err;
    end

    io_strobe_dec #(
        .IO_BITS  (IO_BITS),
        .STB_BITS (STB_BITS)
    ) u_stb (
        .io_hit_i   (io_hit),
        .rd_ok_i    (rd_ok),
        .wr_ok_i    (wr_ok),
        .offs_i     (addr_i[IO_BITS-1:0]),
        .rd_stb_n_o (io_rd_n_o),
        .wr_stb_n_o (io_wr_n_o)
    );

    sram_sel #(
        .RAM_HALF (RAM_HALF)
    ) u_ram (
        .a_msb_i   (addr_i[ADDR_W-1]),
        .cyc_act_i (cyc_act),
        .cyc_err_i (cyc_err),
        .io_hit_i  (io_hit),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .cs_n_o    (ram_cs_n_o),
        .oe_n_o    (ram_oe_n_o),
        .we_n_o    (ram_we_n_o)
    );

    // An idle bus leaves every output inactive (R1)
    always_comb begin
        if (!$isunknown({addr_i, rd_n_i, wr_n_i})) begin
            a_r1_idle_quiet: assert (!(rd_n_i && wr_n_i) ||
                (io_sel_n_o && &io_rd_n_o && &io_wr_n_o && ram_cs_n_o &&
                 ram_oe_n_o && ram_we_n_o && !bus_err_o))
                else $error("output active on idle bus");
        end
    end

endmodule

// File: tb/ext_bus_decoder_bench.sv
`timescale 1ns/1ps
module ext_bus_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc_cnt = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    logic       io_lo, cs_lo, oe_lo, we_lo, er_lo;
    logic [7:0] rs_lo, ws_lo;
    logic       io_hi, cs_hi, oe_hi, we_hi, er_hi;
    logic [7:0] rs_hi, ws_hi;

    ext_bus_decoder #(.RAM_HALF(bus_dec_pkg::RAM_LOW)) u_ext_bus_decoder (
        .addr_i(addr), .rd_n_i(rd_n), .wr_n_i(wr_n),
        .io_sel_n_o(io_lo), .io_rd_n_o(rs_lo), .io_wr_n_o(ws_lo),
        .ram_cs_n_o(cs_lo), .ram_oe_n_o(oe_lo), .ram_we_n_o(we_lo), .bus_err_o(er_lo));

    ext_bus_decoder #(.RAM_HALF(bus_dec_pkg::RAM_HIGH)) u_ext_bus_decoder_up (
        .addr_i(addr), .rd_n_i(rd_n), .wr_n_i(wr_n),
        .io_sel_n_o(io_hi), .io_rd_n_o(rs_hi), .io_wr_n_o(ws_hi),
        .ram_cs_n_o(cs_hi), .ram_oe_n_o(oe_hi), .ram_we_n_o(we_hi), .bus_err_o(er_hi));

    wire [20:0] got_lo = {io_lo, rs_lo, ws_lo, cs_lo, oe_lo, we_lo, er_lo};
    wire [20:0] got_hi = {io_hi, rs_hi, ws_hi, cs_hi, oe_hi, we_hi, er_hi};

    // Reference model written from the requirements
    function automatic logic [20:0] model(input logic up, input logic [15:0] a,
                                          input logic r, input logic w);
        logic act, err, io, cs;
        logic [7:0] rs, ws;
        act = !r || !w;
        err = !r && !w;
        io  = act && (a[15:4] == 12'hFFF);
        rs  = 8'hFF;
        ws  = 8'hFF;
        if (io && !err && !a[3]) begin
            if (!r) rs[a[2:0]] = 1'b0;
            if (!w) ws[a[2:0]] = 1'b0;
        end
        cs = act && !err && (up ? (a[15] && !io) : !a[15]);
        return {!io, rs, ws, !cs, !(!r && !err), !(!w && !err), err};
    endfunction

    task automatic cmp(input string tag, input logic [15:0] a,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s addr=%h rd_n=%b wr_n=%b got=%h exp=%h", tag, a, rd_n, wr_n, got, exp);
        end
    endtask

    // Field-by-field comparison of one instance against an expected vector
    task automatic chk_all(input logic up, input logic [20:0] got, input logic [20:0] exp);
        cmp("R2 io_sel", addr, {7'd0, got[20]}, {7'd0, exp[20]});
        cmp("R3 rd_stb", addr, got[19:12], exp[19:12]);
        cmp("R4 wr_stb", addr, got[11:4],  exp[11:4]);
        cmp(up ? "R7 ram_cs" : "R6 ram_cs", addr, {7'd0, got[3]}, {7'd0, exp[3]});
        cmp("R8 oe_we", addr, {6'd0, got[2:1]}, {6'd0, exp[2:1]});
        cmp("R9 err", addr, {7'd0, got[0]}, {7'd0, exp[0]});
    endtask

    // Drive one stimulus, sample 1 ns later, hold until the 2 ns step ends
    task automatic step(input logic [15:0] a, input logic r, input logic w);
        addr = a; rd_n = r; wr_n = w;
        #1;
        chk_all(1'b0, got_lo, model(1'b0, a, r, w));
        chk_all(1'b1, got_hi, model(1'b1, a, r, w));
        #1;
    endtask

    // Vector: {mode, addr, rd_n, wr_n, io_sel_n, rd_stb, wr_stb, cs_n, oe_n, we_n, err}
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 4'b1110}, // R1 idle
        {1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 4'b0010}, // R6 read low
        {1'b0, 16'h7FFF, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF, 4'b0100}, // R6 write top of low
        {1'b0, 16'h8000, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 4'b1010}, // R8 oe without cs
        {1'b0, 16'hFFF0, 1'b0, 1'b1, 1'b0, 8'hFE, 8'hFF, 4'b1010}, // R3 byte 0
        {1'b0, 16'hFFF7, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h7F, 4'b1100}, // R4 byte 7
        {1'b0, 16'hFFF8, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 4'b1010}, // R5 offset 8
        {1'b1, 16'h8000, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 4'b0010}, // R7 bottom of high
        {1'b1, 16'hFFEF, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF, 4'b0100}, // R7 just below window
        {1'b1, 16'hFFF3, 1'b0, 1'b1, 1'b0, 8'hF7, 8'hFF, 4'b1010}, // R7 window masked, R3
        {1'b1, 16'h7FFF, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 4'b1010}, // R7 low half unselected
        {1'b1, 16'hFFF2, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 4'b1111}, // R9 illegal in window
        {1'b0, 16'h1234, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 4'b1111}, // R9 illegal in RAM
        {1'b1, 16'hFFF5, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 4'b1110}  // R1 idle in window
    };

    // Watchdog: count clocks after reset and end a hung run
    always @(posedge clk) begin
        if (rst_n) cyc_cnt <= cyc_cnt + 1;
        if (!done && cyc_cnt > 150000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired after %0d cycles (expected < 150000)", cyc_cnt);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // Reset phase: idle bus, both placements quiet (R1)
        repeat (3) @(negedge clk);
        cmp("R1 reset lo", addr, {1'b0, got_lo[20:14]} | {7'd0, 1'b0}, 8'h7F);
        cmp("R1 reset lo tail", addr, {got_lo[13:7], got_lo[0]}, 8'hFE);
        cmp("R1 reset lo ram", addr, {got_lo[6:1], 2'b00}, 8'hFC);
        cmp("R1 reset hi", addr, {got_hi[20:13]}, 8'hFF);
        cmp("R1 reset hi ram", addr, {got_hi[12:5]}, 8'hFF);
        cmp("R1 reset hi tail", addr, {3'b000, got_hi[4:0]}, 8'h1E);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            addr = v[38:23]; rd_n = v[22]; wr_n = v[21];
            #1;
            chk_all(v[39], v[39] ? got_hi : got_lo, v[20:0]);
            #1;
        end

        // R5: upper offsets of the window never strobe, for reads and writes
        for (int o = 8; o < 16; o++) begin
            addr = 16'hFFF0 | 16'(o); rd_n = 1'b0; wr_n = 1'b1;
            #1; cmp("R5 rd upper", addr, rs_lo, 8'hFF);
            rd_n = 1'b1; wr_n = 1'b0;
            #1; cmp("R5 wr upper", addr, ws_lo, 8'hFF);
        end

        // R10: change inputs between clock edges and see outputs follow at once
        @(posedge clk); #1;
        addr = 16'hFFF4; rd_n = 1'b0; wr_n = 1'b1;
        #0.5; cmp("R10 same-step rd", addr, rs_lo, 8'hEF);
        addr = 16'h0010;
        #0.5; cmp("R10 same-step cs", addr, {7'd0, cs_lo}, 8'h00);

        // Full sweep: idle, read, write over every address, both placements
        for (int c = 0; c < 3; c++) begin
            for (int a = 0; a < 65536; a++) begin
                step(16'(a), c != 1, c != 2);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule